// File: doc/BRIEF.md
# Pile-up Corrected Hit Discriminator

This block decides, once per bunch period, whether a channel saw a hit. Each accepted sample is a digitised integrated charge. The block first removes the spill-over tail left by the previous period: it subtracts a programmable fraction of the previous accepted sample. It then compares the corrected charge against a threshold. Consecutive samples alternate between two half-rate sub-channels, and each sub-channel has its own threshold. The one-bit decision comes out two cycles after its sample, tagged with the sub-channel that produced it.

The fraction and the two thresholds are loaded through a small write port. A write never lands while a calculation is in progress. A controller with two named states handles this:

- `CFG_IDLE`: a write arriving while the datapath is quiet is committed at once (`IDLE→IDLE`, commit).
- `CFG_IDLE` to `CFG_HELD`: a write arriving while busy is parked in a single held slot (`IDLE→HELD`, park).
- In `CFG_HELD`, a further busy write replaces the parked one (`HELD→HELD`, replace).
- The first idle edge commits the newest write and returns to idle (`HELD→IDLE`, drain).

Top module: `pileup_hit_disc`

## Requirements
- R1: Every cycle with `smp_valid` high yields exactly one result: `hit_valid` is high exactly two cycles after that sample cycle and low in all other cycles. `hit` and `hit_sub` are 0 whenever `hit_valid` is low.
- R2: The sub-channel index is 0 for the first accepted sample after reset and toggles on every accepted sample. `hit_sub` carries the index of the sample that produced the result.
- R3: The corrected value is `smp_data - floor(prev * frac / 2^FRAC_W)`. Here `prev` is the previously accepted sample and `frac` is an unsigned value with FRAC_W fractional bits, so the product is truncated.
- R4: When the subtracted tail exceeds the sample, the corrected value is 0. It never wraps.
- R5: `hit` is 1 only when the corrected value is strictly greater than the threshold of the sample's sub-channel. Threshold 0 serves index 0 and threshold 1 serves index 1. Equality gives 0.
- R6: Synchronous reset clears the previous-sample register, the fraction, both thresholds, the sub-channel index and the outputs. The first sample after reset is therefore not corrected.
- R7: Write select encoding:
  - `cfg_sel`=0 loads the fraction from `cfg_wdata[FRAC_W-1:0]`.
  - `cfg_sel`=1 loads threshold 0.
  - `cfg_sel`=2 loads threshold 1.
  - `cfg_sel`=3 changes nothing.
  - A write is committed at the clock edge where it arrives if no sample is present and no calculation is in flight. FRAC_W must not exceed SAMPLE_W.
- R8: A write that arrives while a sample is present or a calculation is in flight is deferred and committed at the first edge with neither. A later write arriving before that commit replaces the deferred one. Fraction and thresholds never change at a busy edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | SAMPLE_W | Integrated-charge sample, unsigned |
| cfg_we | input | 1 | Configuration write request |
| cfg_sel | input | 2 | Register select, encoding in R7 |
| cfg_wdata | input | SAMPLE_W | Write data |
| hit_valid | output | 1 | Result present |
| hit | output | 1 | Discriminator decision |
| hit_sub | output | 1 | Sub-channel index of the result |

## Verification
The bench builds the block with SAMPLE_W=8 and FRAC_W=8. At these widths, random samples regularly reach full scale and thresholds regularly reach 0. Saturation at zero, equality with a threshold, and the largest fraction (255/256) therefore all occur in the random phase as well as in the directed cases. Short widths also mean random writes often collide with back-to-back samples, which exercises the deferred-write path and its replacement rule.

// File: rtl/pud_pkg.sv
package pud_pkg;

    typedef enum logic [1:0] {
        SEL_FRAC = 2'd0,
        SEL_THR0 = 2'd1,
        SEL_THR1 = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    typedef enum logic {
        CFG_IDLE = 1'b0,
        CFG_HELD = 1'b1
    } cfg_state_e;

    localparam int NUM_SUB = 2;

endpackage

// File: rtl/pud_cfg_ctrl.sv
module pud_cfg_ctrl
    import pud_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int FRAC_W   = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               busy,
    input  logic                               cfg_we,
    input  logic [1:0]                         cfg_sel,
    input  logic [SAMPLE_W-1:0]                cfg_wdata,
    output logic [FRAC_W-1:0]                  frac_q,
    output logic [NUM_SUB-1:0][SAMPLE_W-1:0]   thr_q
);

    cfg_state_e            state_q, state_d;
    logic [1:0]            held_sel_q;
    logic [SAMPLE_W-1:0]   held_data_q;
    logic                  hold_load;
    logic                  commit_en;
    logic [1:0]            commit_sel;
    logic [SAMPLE_W-1:0]   commit_data;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= CFG_IDLE;
        else     state_q <= state_d;
    end

    // Next state and commit decode
    always_comb begin
        state_d     = state_q;
        hold_load   = 1'b0;
        commit_en   = 1'b0;
        commit_sel  = cfg_sel;
        commit_data = cfg_wdata;
        unique case (state_q)
            CFG_IDLE: begin
                if (cfg_we) begin
                    if (busy) begin
                        hold_load = 1'b1;
                        state_d   = CFG_HELD;
                    end else begin
                        commit_en = 1'b1;
                    end
                end
            end
            CFG_HELD: begin
                if (!busy) begin
                    commit_en = 1'b1;
                    state_d   = CFG_IDLE;
                    if (!cfg_we) begin
                        commit_sel  = held_sel_q;
                        commit_data = held_data_q;
                    end
                end else if (cfg_we) begin
                    hold_load = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_sel_q  <= SEL_NONE;
            held_data_q <= '0;
        end else if (hold_load) begin
            held_sel_q  <= cfg_sel;
            held_data_q <= cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            frac_q <= '0;
        else if (commit_en && cfg_sel_e'(commit_sel) == SEL_FRAC)
            frac_q <= commit_data[FRAC_W-1:0];
    end

    generate
        for (genvar g = 0; g < NUM_SUB; g++) begin : g_thr
            localparam logic [1:0] MY_SEL = 2'(g + 1);
            always_ff @(posedge clk) begin
                if (rst)
                    thr_q[g] <= '0;
                else if (commit_en && commit_sel == MY_SEL)
                    thr_q[g] <= commit_data;
            end
        end
    endgenerate

    // R8
    frozen_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(frac_q) && $stable(thr_q)));

    // R8
    held_drains_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == CFG_HELD && !busy) |=> (state_q == CFG_IDLE));

    // R7
    idle_frac_write_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == CFG_IDLE && cfg_we && !busy && cfg_sel == 2'd0)
        |=> (frac_q == $past(cfg_wdata[FRAC_W-1:0])));

endmodule

// File: rtl/pud_correct.sv
module pud_correct #(
    parameter int SAMPLE_W = 12,
    parameter int FRAC_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [FRAC_W-1:0]   frac,
    output logic                s1_valid,
    output logic [SAMPLE_W-1:0] s1_corr,
    output logic                s1_sub
);

    localparam int PROD_W = SAMPLE_W + FRAC_W;

    logic [SAMPLE_W-1:0] prev_q;
    logic                sub_q;
    logic [PROD_W-1:0]   prod;
    logic [SAMPLE_W-1:0] tail;
    logic [SAMPLE_W-1:0] corr;

    always_comb begin
        prod = PROD_W'(prev_q) * PROD_W'(frac);
        tail = prod[PROD_W-1:FRAC_W];
        corr = (smp_data > tail) ? (smp_data - tail) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            sub_q    <= 1'b0;
            s1_valid <= 1'b0;
            s1_corr  <= '0;
            s1_sub   <= 1'b0;
        end else begin
            s1_valid <= smp_valid;
            if (smp_valid) begin
                prev_q  <= smp_data;
                s1_corr <= corr;
                s1_sub  <= sub_q;
                sub_q   <= ~sub_q;
            end
        end
    end

    // R4
    corr_bounded_chk: assert property (@(posedge clk) disable iff (rst)
        s1_valid |-> (s1_corr <= $past(smp_data)));

    // R2
    sub_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> (sub_q != $past(sub_q)));

    // R6
    prev_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (prev_q == '0 && sub_q == 1'b0));

endmodule

// File: rtl/pud_compare.sv
module pud_compare
    import pud_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             s1_valid,
    input  logic [SAMPLE_W-1:0]              s1_corr,
    input  logic                             s1_sub,
    input  logic [NUM_SUB-1:0][SAMPLE_W-1:0] thr,
    output logic                             hit_valid,
    output logic                             hit,
    output logic                             hit_sub
);

    logic [SAMPLE_W-1:0] sel_thr;
    logic                above;

    always_comb begin
        sel_thr = thr[s1_sub];
        above   = s1_corr > sel_thr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_valid <= 1'b0;
            hit       <= 1'b0;
            hit_sub   <= 1'b0;
        end else begin
            hit_valid <= s1_valid;
            hit       <= s1_valid & above;
            hit_sub   <= s1_valid & s1_sub;
        end
    end

    // R1
    quiet_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        !hit_valid |-> (!hit && !hit_sub));

endmodule

// File: rtl/pileup_hit_disc.sv
module pileup_hit_disc
    import pud_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int FRAC_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_sel,
    input  logic [SAMPLE_W-1:0] cfg_wdata,
    output logic                hit_valid,
    output logic                hit,
    output logic                hit_sub
);

    logic [FRAC_W-1:0]                frac;
    logic [NUM_SUB-1:0][SAMPLE_W-1:0] thr;
    logic                             s1_valid;
    logic [SAMPLE_W-1:0]              s1_corr;
    logic                             s1_sub;
    logic                             busy;

    assign busy = smp_valid | s1_valid;

    pud_cfg_ctrl #(.SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .frac_q    (frac),
        .thr_q     (thr)
    );

    pud_correct #(.SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W)) u_corr (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .frac      (frac),
        .s1_valid  (s1_valid),
        .s1_corr   (s1_corr),
        .s1_sub    (s1_sub)
    );

    pud_compare #(.SAMPLE_W(SAMPLE_W)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .s1_valid  (s1_valid),
        .s1_corr   (s1_corr),
        .s1_sub    (s1_sub),
        .thr       (thr),
        .hit_valid (hit_valid),
        .hit       (hit),
        .hit_sub   (hit_sub)
    );

    // R1
    result_has_sample_chk: assert property (@(posedge clk) disable iff (rst)
        hit_valid |-> $past(smp_valid, 2));

    // R1
    sample_has_result_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst, 1) && !$past(rst, 2) && $past(smp_valid, 2)) |-> hit_valid);

    // R6
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !hit_valid);

endmodule

// File: tb/sim_pileup_hit_disc.sv
module sim_pileup_hit_disc;

    localparam int SW = 8;
    localparam int FW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [SW-1:0] cfg_wdata = '0;
    logic          hit_valid, hit, hit_sub;

    int checks = 0;
    int failures = 0;
    int drv_cnt = 0;

    always #10 clk = ~clk;

    pileup_hit_disc #(.SAMPLE_W(SW), .FRAC_W(FW)) u0 (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .hit_valid(hit_valid), .hit(hit), .hit_sub(hit_sub)
    );

    // Reference model state
    int m_prev, m_sub, m_frac, m_thr0, m_thr1;
    int m_held, m_hsel, m_hdata;
    bit e1_v, e1_h, e1_s, e2_v, e2_h, e2_s;

    function automatic int tail_of(int prev, int fr);
        return (prev * fr) >> FW;
    endfunction

    function automatic int corrected(int smp, int prev, int fr);
        int t;
        t = tail_of(prev, fr);
        return (smp > t) ? smp - t : 0;
    endfunction

    task automatic m_apply(int sel, int data);
        case (sel)
            0: m_frac = data & ((1 << FW) - 1);
            1: m_thr0 = data;
            2: m_thr1 = data;
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        bit busy, n_v, n_h, n_s;
        int c;
        if (rst) begin
            m_prev = 0; m_sub = 0; m_frac = 0; m_thr0 = 0; m_thr1 = 0;
            m_held = 0; m_hsel = 3; m_hdata = 0;
            e1_v = 0; e1_h = 0; e1_s = 0; e2_v = 0; e2_h = 0; e2_s = 0;
        end else begin
            busy = smp_valid || e1_v;
            if (m_held == 0) begin
                if (cfg_we) begin
                    if (busy) begin m_held = 1; m_hsel = cfg_sel; m_hdata = cfg_wdata; end
                    else m_apply(cfg_sel, cfg_wdata);
                end
            end else begin
                if (!busy) begin
                    if (cfg_we) m_apply(cfg_sel, cfg_wdata);
                    else m_apply(m_hsel, m_hdata);
                    m_held = 0;
                end else if (cfg_we) begin
                    m_hsel = cfg_sel; m_hdata = cfg_wdata;
                end
            end
            n_v = 0; n_h = 0; n_s = 0;
            if (smp_valid) begin
                c = corrected(smp_data, m_prev, m_frac);
                n_v = 1;
                n_s = m_sub[0];
                n_h = (c > (m_sub[0] ? m_thr1 : m_thr0));
                m_prev = smp_data;
                m_sub = m_sub ^ 1;
            end
            e2_v = e1_v; e2_h = e1_h; e2_s = e1_s;
            e1_v = n_v; e1_h = n_h; e1_s = n_s;
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (hit_valid !== e2_v) begin
                failures++;
                $display("FAIL R1 hit_valid act=%0b exp=%0b", hit_valid, e2_v);
            end
            checks++;
            if (hit !== e2_h) begin
                failures++;
                $display("FAIL R5 hit act=%0b exp=%0b", hit, e2_h);
            end
            checks++;
            if (hit_sub !== e2_s) begin
                failures++;
                $display("FAIL R2 hit_sub act=%0b exp=%0b", hit_sub, e2_s);
            end
        end
    end

    task automatic cfg_write(int sel, int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = SW'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic probe(int data, bit exp_hit, string tag);
        bit exp_sub;
        exp_sub = drv_cnt[0];
        @(negedge clk);
        smp_valid = 1'b1; smp_data = SW'(data);
        drv_cnt++;
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (hit_valid !== 1'b1 || hit !== exp_hit || hit_sub !== exp_sub) begin
            failures++;
            $display("FAIL %s probe act=%0b/%0b/%0b exp=1/%0b/%0b",
                     tag, hit_valid, hit, hit_sub, exp_hit, exp_sub);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit dummy;
        dummy = 0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R6: outputs quiet after reset
        checks++;
        if (hit_valid !== 1'b0) begin
            failures++;
            $display("FAIL R6 reset hit_valid act=%0b exp=0", hit_valid);
        end
        probe(5, 1, "R6");                 // no correction, threshold 0
        cfg_write(0, 128); cfg_write(1, 100); cfg_write(2, 100);
        probe(200, 1, "R3");               // tail 2 -> 198
        probe(150, 0, "R3");               // tail 100 -> 50
        cfg_write(0, 0);
        probe(100, 0, "R5");               // equal to threshold
        probe(101, 1, "R5");
        cfg_write(2, 200);
        probe(150, 0, "R5");               // sub 1 threshold 200
        probe(150, 1, "R5");               // sub 0 threshold 100
        cfg_write(1, 0); cfg_write(2, 0); cfg_write(0, 255);
        probe(255, 1, "R4");               // tail 149 -> 106
        probe(10, 0, "R4");                // tail 254 saturates to 0
        cfg_write(1, 50); cfg_write(2, 50); cfg_write(0, 0);
        cfg_write(3, 0);                   // R7 select 3 changes nothing
        probe(20, 0, "R7");
        // R8: writes during back-to-back samples
        @(negedge clk);
        smp_valid = 1'b1; smp_data = 8'd60; cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 8'd255;
        @(negedge clk);
        cfg_sel = 2'd2;
        @(negedge clk);
        smp_valid = 1'b0; cfg_we = 1'b0;
        drv_cnt += 2;
        repeat (3) @(negedge clk);
        probe(60, 1, "R8");                // threshold 0 untouched (replaced)
        probe(60, 0, "R8");                // threshold 1 took deferred 255
        // Random phase
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            smp_valid = ($urandom % 10) < 7;
            smp_data  = SW'($urandom);
            cfg_we    = ($urandom % 16) == 0;
            cfg_sel   = 2'($urandom);
            cfg_wdata = ($urandom % 4 == 0) ? SW'($urandom % 4) : SW'($urandom);
        end
        @(negedge clk);
        smp_valid = 1'b0; cfg_we = 1'b0;
        repeat (4) @(negedge clk);
        if (dummy) $display("unused");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule